// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits in the master-clock domain of an audio DAC and measures how many master-clock cycles fit into one period of the frame (word-select) clock. It maps that count onto one of six oversampling ratios: 128, 192, 256, 384, 512 or 768 master clocks per frame. It then reports a ratio code, a lock flag and a mute request. Downstream filter and modulator logic follow these outputs to choose their operating rate, and they silence the analog path whenever the master clock and the frame clock do not form a supported relation.

No input selects the ratio. It comes only from the measured period, so the same logic works at any sample rate. A measured period counts as a match when it is no more than 8 cycles away from a nominal ratio. This margin absorbs phase offset and jitter between the two clocks. Lock is declared only when two consecutive frames give the same ratio. A single bad frame, or a frame clock that stops, brings mute back at once.

Top module: `mclk_ratio_detect`

## Requirements
- R1: A frame of N master-clock cycles is classified with a 3-bit code. The code is 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768. N matches a ratio when |N - ratio| <= 8, so an offset of 8 matches and an offset of 9 does not.
- R2: A frame whose length is more than 8 cycles from every supported ratio sets the code to 7, clears lock_valid and sets mute.
- R3: lock_valid rises and mute falls only after the same ratio has been measured on 2 consecutive frames. After the first matching frame the code shows the ratio, but mute stays high.
- R4: One mismatching frame, seen at its closing frame-clock rising edge, clears lock_valid and sets mute at that boundary.
- R5: Frame lengths that vary but stay inside the ±8 window of the locked ratio keep lock_valid high and mute low.
- R6: When the measured ratio changes to another supported ratio, the code shows the new ratio at once and lock_valid stays low until that ratio has been seen on 2 consecutive frames.
- R7: The period counter saturates at 1023. If the frame clock stops, the code goes to 7 and mute is set within 1030 cycles of the last rising edge.
- R8: While enable is low, the code is 7, lock_valid is 0 and mute is 1 from the next clock edge on. Frame edges are ignored while enable is low. After enable returns high, the first rising edge only starts a measurement.
- R9: During and right after reset, the code is 7, lock_valid is 0 and mute is 1.
- R10: The code and lock_valid change only at a measured frame boundary, at counter saturation or when the block is disabled. In the middle of a frame they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; when low, the block is held cleared and muted |
| lrclk_raw | input | 1 | Frame clock, not synchronized to mclk |
| ratio_code | output | 3 | Measured ratio code (0..5), or 7 for no match |
| lock_valid | output | 1 | High when the same ratio has been seen on two consecutive frames |
| mute | output | 1 | Mute request to the DAC path |

## Verification
The hardest state to reach from the ports is the saturation path. In that state no frame edge arrives at all, and the block must still drop lock on its own timing, well after every window has been passed. The bench builds a lock and then holds the frame clock low for more than a thousand cycles. It samples once before saturation, to show that the code is unchanged, and once after. The acceptance boundaries are reached by sweeping each ratio at offsets of 0, ±8 and ±9 cycles, with frame lengths generated exactly by a cycle-counting driver.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIOS = 6;
  localparam logic [2:0] CODE_NONE = 3'd7;

  // Nominal master clocks per frame for each ratio index.
  function automatic int ratio_of(input int idx);
    case (idx)
      0:       ratio_of = 128;
      1:       ratio_of = 192;
      2:       ratio_of = 256;
      3:       ratio_of = 384;
      4:       ratio_of = 512;
      5:       ratio_of = 768;
      default: ratio_of = 0;
    endcase
  endfunction

  // Index of the ratio whose +/-tol window holds count, else CODE_NONE.
  function automatic logic [2:0] classify(input int count, input int tol);
    classify = CODE_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if ((count + tol >= ratio_of(i)) && (count <= ratio_of(i) + tol))
        classify = 3'(i);
    end
  endfunction
endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rise,
  output logic             meas_evt,
  output logic [CNT_W-1:0] meas_count,
  output logic [CNT_W-1:0] period_cnt
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             started_q;
  logic             edge_evt, sat_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (!enable) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (rise) begin
      cnt_q     <= CNT_W'(1);
      started_q <= 1'b1;
    end else if (cnt_q != SAT) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  // A completed frame, or the counter about to saturate with no edge seen.
  assign edge_evt   = enable & rise & started_q;
  assign sat_evt    = enable & ~rise & (cnt_q == SAT - 1'b1);
  assign meas_evt   = edge_evt | sat_evt;
  assign meas_count = edge_evt ? cnt_q : SAT;
  assign period_cnt = cnt_q;
endmodule

// File: rtl/mrd_lock_tracker.sv
module mrd_lock_tracker
  import mrd_pkg::*;
#(
  parameter int LOCK_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       meas_evt,
  input  logic [2:0] meas_code,
  output logic [2:0] code,
  output logic       valid,
  output logic       mute
);
  localparam int MW = $clog2(LOCK_FRAMES + 1);
  localparam logic [MW-1:0] LOCK_N = MW'(LOCK_FRAMES);

  logic [2:0]    code_q, code_d;
  logic [MW-1:0] match_q, match_d;
  logic          valid_q, valid_d, mute_q;

  always_comb begin
    code_d  = code_q;
    match_d = match_q;
    if (meas_evt) begin
      if (meas_code == CODE_NONE) begin
        code_d  = CODE_NONE;
        match_d = '0;
      end else if (meas_code == code_q) begin
        if (match_q < LOCK_N) match_d = match_q + 1'b1;
      end else begin
        code_d  = meas_code;
        match_d = MW'(1);
      end
    end
    valid_d = meas_evt ? (match_d == LOCK_N) : valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CODE_NONE;
      match_q <= '0;
      valid_q <= 1'b0;
      mute_q  <= 1'b1;
    end else if (!enable) begin
      code_q  <= CODE_NONE;
      match_q <= '0;
      valid_q <= 1'b0;
      mute_q  <= 1'b1;
    end else begin
      code_q  <= code_d;
      match_q <= match_d;
      valid_q <= valid_d;
      mute_q  <= ~valid_d;
    end
  end

  assign code  = code_q;
  assign valid = valid_q;
  assign mute  = mute_q;
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 8,
  parameter int LOCK_FRAMES = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       lrclk_raw,
  output logic [2:0] ratio_code,
  output logic       lock_valid,
  output logic       mute
);
  logic             frame_rise;
  logic             meas_evt;
  logic [CNT_W-1:0] meas_count;
  logic [CNT_W-1:0] period_cnt;
  logic [2:0]       meas_code;

  mrd_edge_sync u_sync (
    .clk  (mclk),
    .rst_n(rst_n),
    .din  (lrclk_raw),
    .rise (frame_rise)
  );

  mrd_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (mclk),
    .rst_n     (rst_n),
    .enable    (enable),
    .rise      (frame_rise),
    .meas_evt  (meas_evt),
    .meas_count(meas_count),
    .period_cnt(period_cnt)
  );

  assign meas_code = classify(int'(meas_count), TOL);

  mrd_lock_tracker #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk      (mclk),
    .rst_n    (rst_n),
    .enable   (enable),
    .meas_evt (meas_evt),
    .meas_code(meas_code),
    .code     (ratio_code),
    .valid    (lock_valid),
    .mute     (mute)
  );
endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             meas_evt,
  input logic [2:0]       meas_code,
  input logic [CNT_W-1:0] period_cnt,
  input logic [2:0]       ratio_code,
  input logic             lock_valid,
  input logic             mute
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  AST_VALID_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_valid |-> (ratio_code != 3'd7 && !mute));                        // R1
  AST_MISMATCH_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && meas_evt && meas_code == 3'd7) |=> (mute && !lock_valid && ratio_code == 3'd7)); // R2
  AST_LOCK_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_valid) |-> $past(meas_evt));                               // R3
  AST_NEW_RATIO_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && meas_evt && meas_code != 3'd7 && meas_code != ratio_code) |=> !lock_valid); // R6
  AST_SAT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (period_cnt == SAT) |-> (mute && ratio_code == 3'd7));                // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (mute && !lock_valid && ratio_code == 3'd7));             // R8
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !meas_evt) |=> ($stable(ratio_code) && $stable(lock_valid))); // R10
endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (mclk),
  .rst_n     (rst_n),
  .enable    (enable),
  .meas_evt  (meas_evt),
  .meas_code (meas_code),
  .period_cnt(period_cnt),
  .ratio_code(ratio_code),
  .lock_valid(lock_valid),
  .mute      (mute)
);

// File: tb/mclk_ratio_detect_test.sv
module mclk_ratio_detect_test;
  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       lrclk_raw = 1'b0;
  logic [2:0] ratio_code;
  logic       lock_valid, mute;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #10 mclk = ~mclk;

  mclk_ratio_detect uut (
    .mclk(mclk), .rst_n(rst_n), .enable(enable), .lrclk_raw(lrclk_raw),
    .ratio_code(ratio_code), .lock_valid(lock_valid), .mute(mute)
  );

  // Ratios written as multiples of 64: 2,3,4,6,8,12.
  function automatic logic [2:0] exp_code(input int n);
    int mult[6] = '{2, 3, 4, 6, 8, 12};
    exp_code = 3'd7;
    for (int k = 0; k < 6; k++) begin
      int d = n - 64 * mult[k];
      if (d < 0) d = -d;
      if (d <= 8) exp_code = 3'(k);
    end
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic check_out(input string tag, input logic [2:0] ec, input logic ev, input logic em);
    checks++;
    if (ratio_code !== ec || lock_valid !== ev || mute !== em) begin
      fails++;
      $display("FAIL %s: code/valid/mute = %0d/%0b/%0b, expected %0d/%0b/%0b",
               tag, ratio_code, lock_valid, mute, ec, ev, em);
    end
  endtask

  task automatic frame(input int n);
    lrclk_raw = 1'b1; cyc(n / 2);
    lrclk_raw = 1'b0; cyc(n - n / 2);
  endtask

  // Raise the frame clock (closing the previous frame), check, then finish a frame of n.
  task automatic edge_chk(input int n, input string tag, input logic [2:0] ec, input logic ev, input logic em);
    lrclk_raw = 1'b1; cyc(4);
    check_out(tag, ec, ev, em);
    cyc(n / 2 - 4);
    lrclk_raw = 1'b0; cyc(n - n / 2);
  endtask

  initial begin
    cyc(200_000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check_out("R9 in reset", 3'd7, 1'b0, 1'b1);
    rst_n = 1'b1;
    cyc(2);
    check_out("R9 after reset", 3'd7, 1'b0, 1'b1);

    // R1 / R2 sweep: every ratio at offsets 0, +/-8, +/-9.
    for (int r = 0; r < 6; r++) begin
      for (int o = 0; o < 5; o++) begin
        int offs[5] = '{0, 8, -8, 9, -9};
        int n = ((r == 0) ? 128 : (r == 1) ? 192 : (r == 2) ? 256 :
                 (r == 3) ? 384 : (r == 4) ? 512 : 768) + offs[o];
        logic [2:0] ec = exp_code(n);
        frame(n); frame(n);
        edge_chk(n, (ec == 3'd7) ? "R2 sweep" : "R1 sweep", ec, ec != 3'd7, ec == 3'd7);
      end
    end

    // R3 / R4: lock needs two frames, one bad frame unlocks.
    frame(300); frame(300);
    edge_chk(256, "R2 300 cycles", 3'd7, 1'b0, 1'b1);
    edge_chk(256, "R3 first match", 3'd2, 1'b0, 1'b1);
    edge_chk(300, "R3 second match", 3'd2, 1'b1, 1'b0);
    edge_chk(256, "R4 single bad frame", 3'd7, 1'b0, 1'b1);
    edge_chk(256, "R3 relock first", 3'd2, 1'b0, 1'b1);
    edge_chk(512, "R3 relock second", 3'd2, 1'b1, 1'b0);
    // R6: ratio change.
    edge_chk(512, "R6 new ratio", 3'd4, 1'b0, 1'b1);
    edge_chk(520, "R6 new ratio locked", 3'd4, 1'b1, 1'b0);
    // R5: jitter inside the window.
    edge_chk(504, "R5 +8 jitter", 3'd4, 1'b1, 1'b0);
    edge_chk(515, "R5 -8 jitter", 3'd4, 1'b1, 1'b0);
    // R7 / R10: stopped frame clock.
    lrclk_raw = 1'b1; cyc(4);
    check_out("R5 +3 jitter", 3'd4, 1'b1, 1'b0);
    cyc(100); lrclk_raw = 1'b0; cyc(896);
    check_out("R10 mid-frame hold", 3'd4, 1'b1, 1'b0);
    cyc(100);
    check_out("R7 stopped clock", 3'd7, 1'b0, 1'b1);

    // R8: enable.
    frame(384); frame(384);
    edge_chk(384, "R8 lock before disable", 3'd3, 1'b1, 1'b0);
    enable = 1'b0; cyc(2);
    check_out("R8 disabled", 3'd7, 1'b0, 1'b1);
    frame(384); frame(384);
    lrclk_raw = 1'b1; cyc(4);
    check_out("R8 edges ignored", 3'd7, 1'b0, 1'b1);
    cyc(188); lrclk_raw = 1'b0; cyc(100);
    enable = 1'b1; cyc(92);
    edge_chk(384, "R8 first edge only starts", 3'd7, 1'b0, 1'b1);
    edge_chk(384, "R8 first measure", 3'd3, 1'b0, 1'b1);
    edge_chk(384, "R8 relocked", 3'd3, 1'b1, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule